// File: doc/BRIEF.md
# Two-Wire EEPROM Write-Command Receiver

This block is the receive side of a serial EEPROM that sits on a two-wire bus. It oversamples the bus clock and data lines with the system clock and finds START and STOP conditions. It assembles bytes MSB first and pulls the data line low on the ninth clock of each byte it accepts. It accepts a transfer only when the first byte names this device: a fixed four-bit type code, three chip-select bits that match the strapped pins, and a clear direction bit (write).

Once the control byte is accepted, the next two bytes form a word address, high byte first. The top bit of the high byte is ignored, which leaves a 15-bit address. The block presents the address with a one-cycle load strobe. Each byte after that is handed to the page store with a one-cycle data strobe. A STOP produces a one-cycle pulse that the write engine uses to start its cycle. While that engine reports a write in progress, the receiver acknowledges nothing, not even its own control byte.

Top module: `eeprom_write_rx`

## Requirements
- R1: A START condition (data falling while clock is high) begins reception of a control byte, both from idle and as a repeated START in the middle of a transfer.
- R2: A STOP condition (data rising while clock is high) returns the receiver to idle, releases the data line and raises `stop_pulse` for exactly one cycle. After reset the data line is released and all strobes are low.
- R3: Data bits are sampled on rising clock edges, most significant bit first.
- R4: The acknowledge drive (`sda_pull` high) starts after the falling clock edge that ends the eighth bit and ends after the falling edge that ends the ninth clock, so that it covers the whole high phase of the ninth clock.
- R5: The control byte is acknowledged only when bits 7..4 equal 4'b1010, bits 3..1 equal `chip_sel`, and bit 0 is 0. Any other control byte is not acknowledged, and all further bytes are ignored until the next START.
- R6: The two bytes after the control byte are acknowledged. After the second of them, `addr_load` pulses for one cycle with `addr_word` = {high byte bits 6..0, low byte}. Bit 7 of the high byte has no effect.
- R7: Every byte after the address bytes is acknowledged, and `data_valid` pulses for one cycle with that byte on `data_byte`, any number of times per transfer.
- R8: When `write_busy` is high at the end of any byte, that byte is not acknowledged and the receiver goes idle, with no strobe for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| chip_sel | input | 3 | Strapped chip-select pins |
| write_busy | input | 1 | Internal write cycle in progress |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| addr_load | output | 1 | One-cycle strobe: word address ready |
| addr_word | output | ADDR_W (15) | Captured word address |
| data_valid | output | 1 | One-cycle strobe: data byte ready |
| data_byte | output | 8 | Received data byte |
| stop_pulse | output | 1 | One-cycle pulse on STOP |

## Verification
The bench uses the default parameters: two synchroniser stages, type code 1010 and a 15-bit address. With these values the all-ones address 7FFF is the upper edge of the array. A high byte whose top bit is set shows that the bit is ignored. The chip-select strap is 3'b101, so a control byte that differs from it in one bit exercises the match logic. The bus half-period is eight system clocks, which is long enough for the two-stage synchroniser and the registered acknowledge drive to settle inside each clock phase.

// File: rtl/eewr_pkg.sv
// Shared types for the EEPROM write-command receiver.
package eewr_pkg;
    localparam int BYTE_W = 8;
    localparam int CS_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA
    } eewr_state_t;
endpackage

// File: rtl/eewr_line_sync.sv
// Brings the bus clock and data lines into the clk domain and derives
// clock edges and START/STOP events from them.
// Assumes the bus is far slower than clk (several clk cycles per phase).
module eewr_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic scl_s, scl_p, sda_p;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first synchroniser flop, reset to idle-high bus
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_in;
                    sda_ff[g] <= sda_in;
                end
            end
        end else begin : g_next
            // later synchroniser flops
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    // previous synchronised values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_evt = scl_s & scl_p & sda_p & ~sda_s;
        stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/eewr_bit_engine.sv
// Shifts bits in on clock rises, flags the end of each byte at the falling
// edge after the eighth bit, and holds the acknowledge drive through the
// ninth clock when the frame controller accepts the byte.
// Assumes the events come from eewr_line_sync.
module eewr_bit_engine
    import eewr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              ack_ok,
    output logic              byte_end,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_low
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_ack;

    // end of the eighth bit: first falling edge with a full byte
    assign byte_end = active & ~in_ack & scl_fall & (bit_cnt == FULL);
    assign rx_byte  = shreg;

    // bit counter, shift register and acknowledge phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_low <= 1'b0;
        end else if (start_evt || stop_evt || !active) begin
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_low <= 1'b0;
        end else if (in_ack) begin
            if (scl_fall) begin
                in_ack  <= 1'b0;
                sda_low <= 1'b0;
                bit_cnt <= '0;
            end
        end else if (byte_end) begin
            if (ack_ok) begin
                in_ack  <= 1'b1;
                sda_low <= 1'b1;
            end else begin
                bit_cnt <= '0;
            end
        end else if (scl_rise && bit_cnt < FULL) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R4: the drive only begins after a falling clock edge
    p_ack_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> $past(scl_fall));

    // R4: the drive only ends after a falling edge or a bus condition
    p_release_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low) |-> $past(scl_fall || start_evt || stop_evt || !active));
endmodule

// File: rtl/eewr_frame_ctrl.sv
// Frame sequencer: checks the control byte, collects the two address
// bytes and issues address, data and stop strobes.
// Assumes byte_end comes from eewr_bit_engine with rx_byte stable.
module eewr_frame_ctrl
    import eewr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter int         ADDR_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_end,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CS_W-1:0]   chip_sel,
    input  logic              write_busy,
    output eewr_state_t       state,
    output logic              ack_ok,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_word,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte,
    output logic              stop_pulse
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [HI_W-1:0] hi_q;
    logic            ctrl_match;

    // decide whether the byte just completed is accepted
    always_comb begin
        ctrl_match = (rx_byte == {DEV_CODE, chip_sel, 1'b0});
        case (state)
            ST_CTRL:                        ack_ok = ctrl_match & ~write_busy;
            ST_ADDR_HI, ST_ADDR_LO, ST_DATA: ack_ok = ~write_busy;
            default:                        ack_ok = 1'b0;
        endcase
    end

    // frame sequencing and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hi_q       <= '0;
            addr_word  <= '0;
            addr_load  <= 1'b0;
            data_byte  <= '0;
            data_valid <= 1'b0;
            stop_pulse <= 1'b0;
        end else begin
            addr_load  <= 1'b0;
            data_valid <= 1'b0;
            stop_pulse <= stop_evt;
            if (stop_evt) begin
                state <= ST_IDLE;
            end else if (start_evt) begin
                state <= ST_CTRL;
            end else if (byte_end) begin
                if (!ack_ok) begin
                    state <= ST_IDLE;
                end else begin
                    case (state)
                        ST_CTRL: state <= ST_ADDR_HI;
                        ST_ADDR_HI: begin
                            hi_q  <= rx_byte[HI_W-1:0];
                            state <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            addr_word <= {hi_q, rx_byte};
                            addr_load <= 1'b1;
                            state     <= ST_DATA;
                        end
                        ST_DATA: begin
                            data_byte  <= rx_byte;
                            data_valid <= 1'b1;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R1: a START alone always leads to control-byte reception
    p_start_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt && !stop_evt |=> state == ST_CTRL);

    // R2: a STOP idles the sequencer and raises the pulse
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE) && stop_pulse);

    // R2: the stop pulse lasts a single cycle
    p_stop_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    // R6: the address load follows the low address byte and lasts one cycle
    p_load_after_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> $past(state) == ST_ADDR_LO && state == ST_DATA);

    p_load_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> !addr_load);

    // R7: data strobes only come from the data phase
    p_data_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(state) == ST_DATA);
endmodule

// File: rtl/eeprom_write_rx.sv
// Top of the EEPROM write-command receiver: synchroniser, bit engine and
// frame controller. sda_pull is the active-high enable of an open-drain
// pull-down on the data line.
// Assumes chip_sel is static and write_busy is synchronous to clk.
module eeprom_write_rx
    import eewr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         ADDR_W      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        chip_sel,
    input  logic              write_busy,
    output logic              sda_pull,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_word,
    output logic              data_valid,
    output logic [7:0]        data_byte,
    output logic              stop_pulse
);
    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              byte_end, ack_ok;
    logic [BYTE_W-1:0] rx_byte;
    eewr_state_t       state;

    eewr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    eewr_bit_engine u_bits (
        .clk(clk), .rst_n(rst_n), .active(state != ST_IDLE),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .ack_ok(ack_ok), .byte_end(byte_end), .rx_byte(rx_byte),
        .sda_low(sda_pull)
    );

    eewr_frame_ctrl #(.DEV_CODE(DEV_CODE), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_end(byte_end), .rx_byte(rx_byte), .chip_sel(chip_sel),
        .write_busy(write_busy), .state(state), .ack_ok(ack_ok),
        .addr_load(addr_load), .addr_word(addr_word),
        .data_valid(data_valid), .data_byte(data_byte),
        .stop_pulse(stop_pulse)
    );

    // R8: a byte that ends while busy is never acknowledged
    p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end && write_busy |=> !sda_pull);

    // R5: a rejected byte leaves the receiver idle
    p_reject_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end && !ack_ok && !start_evt |=> state == ST_IDLE);
endmodule

// File: tb/eeprom_write_rx_test.sv
module eeprom_write_rx_test;
    localparam int Q = 8;
    localparam logic [2:0] CS = 3'b101;
    localparam int NV = 7;
    // {ctrl, addr_hi, addr_lo, d0, d1, busy, expect_accept}
    localparam logic [41:0] VEC [NV] = '{
        {8'hAA, 8'h12, 8'h34, 8'h56, 8'h78, 1'b0, 1'b1},
        {8'hAA, 8'hF2, 8'h01, 8'hA5, 8'h5A, 1'b0, 1'b1},
        {8'hAB, 8'h00, 8'h01, 8'h11, 8'h22, 1'b0, 1'b0},
        {8'hA8, 8'h00, 8'h02, 8'h33, 8'h44, 1'b0, 1'b0},
        {8'h2A, 8'h00, 8'h03, 8'h55, 8'h66, 1'b0, 1'b0},
        {8'hAA, 8'h00, 8'h04, 8'h77, 8'h88, 1'b1, 1'b0},
        {8'hAA, 8'h7F, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic write_busy = 1'b0;
    logic sda_pull, addr_load, data_valid, stop_pulse;
    logic [14:0] addr_word;
    logic [7:0] data_byte;
    wire sda_line = sda_m & ~sda_pull;

    int checks = 0, fails = 0;
    int n_load = 0, n_data = 0, n_stop = 0;
    logic [14:0] last_addr = '0;
    logic [7:0] dlog [8];

    always #2 clk = ~clk;

    eeprom_write_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .chip_sel(CS), .write_busy(write_busy), .sda_pull(sda_pull),
        .addr_load(addr_load), .addr_word(addr_word),
        .data_valid(data_valid), .data_byte(data_byte),
        .stop_pulse(stop_pulse)
    );

    // strobe monitor
    always @(posedge clk) begin
        if (addr_load) begin
            n_load <= n_load + 1;
            last_addr <= addr_word;
        end
        if (data_valid) begin
            dlog[n_data % 8] <= data_byte;
            n_data <= n_data + 1;
        end
        if (stop_pulse) n_stop <= n_stop + 1;
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(2); scl = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q); scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2);
        end
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q / 2);
        ack = ~sda_line;
        wt(Q / 2); scl = 1'b0; wt(Q);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        bit a;
        int l0, d0, s0, acks;
        wt(4);
        // R2: reset state
        check(sda_pull == 0 && addr_load == 0 && data_valid == 0 && stop_pulse == 0,
              "R2 reset", {sda_pull, addr_load, data_valid, stop_pulse}, 0);
        rst_n = 1'b1; wt(4);

        // vector table: R3 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [41:0] e;
            e = VEC[v];
            l0 = n_load; d0 = n_data; s0 = n_stop; acks = 0;
            write_busy = e[1];
            bus_start();
            send_byte(e[41:34], a);
            check(a == e[0], "R5 R8 control ack", a, e[0]);
            acks += a;
            send_byte(e[33:26], a); acks += a;
            send_byte(e[25:18], a); acks += a;
            send_byte(e[17:10], a); acks += a;
            send_byte(e[9:2], a);   acks += a;
            check(sda_pull == 0, "R4 release after ack", sda_pull, 0);
            bus_stop();
            wt(4);
            write_busy = 1'b0;
            check(acks == (e[0] ? 5 : 0), "R5 R6 R7 ack count", acks, e[0] ? 5 : 0);
            check(n_stop - s0 == 1, "R2 stop pulse", n_stop - s0, 1);
            if (e[0]) begin
                check(n_load - l0 == 1 && last_addr == {e[32:26], e[25:18]},
                      "R3 R6 address", last_addr, {e[32:26], e[25:18]});
                check(n_data - d0 == 2 && dlog[d0 % 8] == e[17:10] && dlog[(d0 + 1) % 8] == e[9:2],
                      "R7 data bytes", {dlog[d0 % 8], dlog[(d0 + 1) % 8]}, {e[17:10], e[9:2]});
            end else begin
                check(n_load == l0 && n_data == d0, "R5 R8 no strobes",
                      n_load - l0 + n_data - d0, 0);
            end
        end

        // R1: repeated START in the middle of the address
        l0 = n_load; d0 = n_data;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h12, a);
        bus_start();
        send_byte(8'hAA, a);
        check(a == 1, "R1 control ack after repeated start", a, 1);
        send_byte(8'h00, a); send_byte(8'h10, a); send_byte(8'h33, a);
        bus_stop(); wt(4);
        check(n_load - l0 == 1 && last_addr == 15'h0010, "R1 address after restart", last_addr, 15'h0010);
        check(n_data - d0 == 1 && dlog[d0 % 8] == 8'h33, "R1 data after restart", n_data - d0, 1);

        // R2: STOP mid-address, then bytes with no START are ignored
        l0 = n_load; s0 = n_stop;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h01, a);
        bus_stop(); wt(4);
        check(n_stop - s0 == 1, "R2 stop mid address", n_stop - s0, 1);
        scl = 1'b0; wt(2);
        send_byte(8'hAA, a);
        check(a == 0, "R2 no ack without start", a, 0);
        send_byte(8'h02, a);
        check(n_load == l0, "R2 no load after stop", n_load - l0, 0);
        scl = 1'b1; wt(Q);

        // R8: busy rises during the address
        l0 = n_load;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h03, a);
        write_busy = 1'b1;
        send_byte(8'h04, a);
        check(a == 0, "R8 low address refused while busy", a, 0);
        write_busy = 1'b0;
        send_byte(8'h05, a);
        check(a == 0, "R8 stays idle after refusal", a, 0);
        bus_stop(); wt(4);
        check(n_load == l0, "R8 no load", n_load - l0, 0);

        // R7: long data run, R6: high-bit-set address
        l0 = n_load; d0 = n_data;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h80, a); send_byte(8'h00, a);
        for (int k = 0; k < 5; k++) send_byte(8'hC0 + 8'(k), a);
        check(a == 1, "R7 fifth data byte ack", a, 1);
        bus_stop(); wt(4);
        check(last_addr == 15'h0000 && n_load - l0 == 1, "R6 top bit ignored", last_addr, 0);
        check(n_data - d0 == 5 && dlog[(d0 + 4) % 8] == 8'hC4, "R7 five strobes", n_data - d0, 5);

        finish_up();
    end
endmodule